// File: doc/BRIEF.md
# History Buffer State Restore

This block lets a processor that writes results straight into its working register file, as soon as each instruction finishes, still recover a precise state after an exception. Every issuing instruction claims one slot of a circular buffer. Into that slot go the value its destination register holds just before it is overwritten, the register number and the instruction's PC. The value is read through a spare read port of the external register file. If a result for that same register is landing on the same cycle, the result is taken instead. The slot index is handed back as a tag. The execution pipeline later reports only exception status against that tag.

Slots at the head whose instructions finished cleanly are freed in order. When the head slot reports an exception, the buffer freezes and issue stops. The block then waits until the pipeline reports that no work is outstanding. It then walks the live slots from the youngest back to the head, one per cycle. Each saved old value is written back through a dedicated write port, so the oldest value for any register is written last. At the end it raises a done flag and presents the faulting instruction's PC as the precise PC. Only reset leaves this state.

Issue is a valid/ready stream. An issue is taken on a clock edge where both `iss_valid` and `iss_ready` are high. `iss_ready` is low while all slots are in use. It is also low from the first cycle the head slot shows an exception, and it stays low from then on. The other ports are plain control and status pins.

Top module: `hist_restore_unit`

## Requirements
- R1: On an accepted issue the slot at the tail takes the destination number, the old value on `rd_data` (read at `rd_addr`, which equals `iss_dst`) and `iss_pc`. `iss_tag` shows the tail slot index before the issue. Tags run 0,1,...,DEPTH-1 and then wrap to 0.
- R2: If `byp_valid` is high and `byp_dst` equals `iss_dst` on the issue cycle, the saved old value is `byp_data` and not `rd_data`.
- R3: `cmp_valid` with `cmp_tag` marks that slot finished with exception flag `cmp_exc`. Only the head slot is freed, one per cycle, when it is finished without exception. A finished slot behind an unfinished head frees nothing.
- R4: With DEPTH slots live, `iss_ready` is low. It returns high in the cycle after a slot is freed.
- R5: From the cycle after an exception report for the head slot, `iss_ready` is low and stays low. From that point no slot is freed and no issue is taken, even with `iss_valid` high.
- R6: After the exception no restore write (`rw_en`) occurs while `pipe_idle` is low. The first write appears in the cycle after `pipe_idle` is seen high.
- R7: The restore writes one slot per consecutive cycle, from the youngest live slot to the head slot. It drives `rw_addr`/`rw_data` with that slot's register number and saved old value, and it writes exactly as many times as there are live slots.
- R8: After the last write, `restore_done` is high and `precise_pc` equals the head slot's PC. Both hold until reset, and `precise_pc` is zero while `restore_done` is low.
- R9: After reset `iss_ready` is high, `iss_tag` is 0, and `rw_en` and `restore_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Slot available and block running |
| iss_dst | input | RW | Destination register of issuing instruction |
| iss_pc | input | PW | PC of issuing instruction |
| iss_tag | output | AW | Slot index given to the issuing instruction |
| rd_addr | output | RW | Extra read port address into the register file |
| rd_data | input | DW | Current value read from the register file |
| byp_valid | input | 1 | A result is being written into the file this cycle |
| byp_dst | input | RW | Register that result targets |
| byp_data | input | DW | Value of that result |
| cmp_valid | input | 1 | Completion status report |
| cmp_tag | input | AW | Slot the report belongs to |
| cmp_exc | input | 1 | Report carries an exception |
| pipe_idle | input | 1 | No instruction outstanding in the pipeline |
| rw_en | output | 1 | Restore write enable |
| rw_addr | output | RW | Restore write register number |
| rw_data | output | DW | Restore write value |
| restore_done | output | 1 | Restore complete, precise state present |
| precise_pc | output | PW | PC of the faulting instruction once done |

## Verification
Status reports are registered, so a report made on one edge changes `iss_ready` one edge later. A freed slot needs one more edge: the report is registered on the first edge, and the head moves on the second. The restore state machine takes one edge to enter draining and one edge after `pipe_idle` is seen to start writing. Each later write comes on the next edge, and `restore_done` rises on the edge after the last write. The bench drives inputs on the falling edge and checks on a falling edge. It counts exactly these edge latencies after each stimulus. Restore writes are checked at consecutive falling edges, in the youngest-to-head order that the bench's own record of issued slots predicts.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  typedef enum logic [1:0] {
    HB_RUN   = 2'd0,
    HB_DRAIN = 2'd1,
    HB_WALK  = 2'd2,
    HB_DONE  = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hbr_capture.sv
module hbr_capture #(
  parameter int RW = 5,
  parameter int DW = 32,
  parameter bit HAS_BYPASS = 1'b1
) (
  input  logic [RW-1:0] iss_dst,
  input  logic [DW-1:0] rd_data,
  input  logic          byp_valid,
  input  logic [RW-1:0] byp_dst,
  input  logic [DW-1:0] byp_data,
  output logic [DW-1:0] old_val
);
  generate
    if (HAS_BYPASS) begin : g_byp
      logic hit;
      assign hit     = byp_valid && (byp_dst == iss_dst);
      assign old_val = hit ? byp_data : rd_data;
    end else begin : g_nobyp
      logic [RW+DW:0] unused_in;
      assign unused_in = {byp_valid, byp_dst, byp_data};
      assign old_val   = rd_data;
    end
  endgenerate
endmodule

// File: rtl/hbr_ring.sv
module hbr_ring #(
  parameter int DEPTH = 8,
  parameter int RW = 5,
  parameter int DW = 32,
  parameter int PW = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [RW-1:0] push_dst,
  input  logic [DW-1:0] push_old,
  input  logic [PW-1:0] push_pc,
  input  logic          cmp_valid,
  input  logic [AW-1:0] cmp_tag,
  input  logic          cmp_exc,
  input  logic          pop,
  input  logic [AW-1:0] rd_idx,
  output logic [RW-1:0] rd_dst,
  output logic [DW-1:0] rd_old,
  output logic [PW-1:0] head_pc,
  output logic          head_fin,
  output logic          head_exc,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic          full,
  output logic          empty
);
  logic [RW-1:0] dst_mem [DEPTH];
  logic [DW-1:0] old_mem [DEPTH];
  logic [PW-1:0] pc_mem  [DEPTH];
  logic [DEPTH-1:0] fin_q, exc_q;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      dst_mem[tail] <= push_dst;
      old_mem[tail] <= push_old;
      pc_mem[tail]  <= push_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_q <= '0;
      exc_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && tail == AW'(i)) begin
          fin_q[i] <= 1'b0;
          exc_q[i] <= 1'b0;
        end else if (cmp_valid && cmp_tag == AW'(i)) begin
          fin_q[i] <= 1'b1;
          exc_q[i] <= cmp_exc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign head_fin = fin_q[head];
  assign head_exc = exc_q[head];
  assign head_pc  = pc_mem[head];
  assign rd_dst   = dst_mem[rd_idx];
  assign rd_old   = old_mem[rd_idx];

  // R4: occupancy never exceeds the slot count, and a full ring refuses pushes
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R3: only a finished, clean, live head may be freed
  p_pop_clean_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (!empty && head_fin && !head_exc));
endmodule

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
  import hbr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_fin,
  input  logic          head_exc,
  input  logic          empty,
  input  logic [AW-1:0] head,
  input  logic [AW-1:0] tail,
  input  logic          pipe_idle,
  output logic          issue_ok,
  output logic          pop,
  output logic          walk_we,
  output logic [AW-1:0] walk_idx,
  output logic          done
);
  hb_state_e state;
  logic      trap;

  function automatic logic [AW-1:0] back(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign trap     = (state == HB_RUN) && !empty && head_fin && head_exc;
  assign pop      = (state == HB_RUN) && !empty && head_fin && !head_exc;
  assign issue_ok = (state == HB_RUN) && !trap;
  assign walk_we  = (state == HB_WALK);
  assign done     = (state == HB_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= HB_RUN;
      walk_idx <= '0;
    end else begin
      case (state)
        HB_RUN:   if (trap) state <= HB_DRAIN;
        HB_DRAIN: if (pipe_idle) begin
          state    <= HB_WALK;
          walk_idx <= back(tail);
        end
        HB_WALK: begin
          if (walk_idx == head) state <= HB_DONE;
          else walk_idx <= back(walk_idx);
        end
        default:  state <= HB_DONE;
      endcase
    end
  end

  // R6: the first restore write follows a cycle with the pipeline idle
  p_walk_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_we) |-> $past(pipe_idle));
  // R7: consecutive restore writes step one slot toward the head
  p_walk_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_we && $past(walk_we)) |-> (walk_idx == back($past(walk_idx))));
  // R5: once out of the running state nothing retires or issues
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != HB_RUN) |-> (!pop && !issue_ok));
  // R8: done is sticky until reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/hist_restore_unit.sv
module hist_restore_unit #(
  parameter int DEPTH = 8,
  parameter int RW = 5,
  parameter int DW = 32,
  parameter int PW = 32,
  parameter bit HAS_BYPASS = 1'b1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic [RW-1:0] iss_dst,
  input  logic [PW-1:0] iss_pc,
  output logic [AW-1:0] iss_tag,
  output logic [RW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          byp_valid,
  input  logic [RW-1:0] byp_dst,
  input  logic [DW-1:0] byp_data,
  input  logic          cmp_valid,
  input  logic [AW-1:0] cmp_tag,
  input  logic          cmp_exc,
  input  logic          pipe_idle,
  output logic          rw_en,
  output logic [RW-1:0] rw_addr,
  output logic [DW-1:0] rw_data,
  output logic          restore_done,
  output logic [PW-1:0] precise_pc
);
  logic [DW-1:0] old_val;
  logic          push, pop, issue_ok, walk_we, done;
  logic          head_fin, head_exc, full, empty;
  logic [AW-1:0] head, tail, walk_idx;
  logic [PW-1:0] head_pc;

  hbr_capture #(.RW(RW), .DW(DW), .HAS_BYPASS(HAS_BYPASS)) u_cap (
    .iss_dst(iss_dst), .rd_data(rd_data), .byp_valid(byp_valid),
    .byp_dst(byp_dst), .byp_data(byp_data), .old_val(old_val)
  );

  hbr_ring #(.DEPTH(DEPTH), .RW(RW), .DW(DW), .PW(PW)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .push_dst(iss_dst),
    .push_old(old_val), .push_pc(iss_pc), .cmp_valid(cmp_valid),
    .cmp_tag(cmp_tag), .cmp_exc(cmp_exc), .pop(pop), .rd_idx(walk_idx),
    .rd_dst(rw_addr), .rd_old(rw_data), .head_pc(head_pc),
    .head_fin(head_fin), .head_exc(head_exc), .head(head), .tail(tail),
    .full(full), .empty(empty)
  );

  hbr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .head_fin(head_fin), .head_exc(head_exc),
    .empty(empty), .head(head), .tail(tail), .pipe_idle(pipe_idle),
    .issue_ok(issue_ok), .pop(pop), .walk_we(walk_we),
    .walk_idx(walk_idx), .done(done)
  );

  assign iss_ready    = issue_ok && !full;
  assign push         = iss_valid && iss_ready;
  assign iss_tag      = tail;
  assign rd_addr      = iss_dst;
  assign rw_en        = walk_we;
  assign restore_done = done;
  assign precise_pc   = done ? head_pc : '0;

  // R8: the precise PC does not move once the restore has finished
  p_pc_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_done && $past(restore_done)) |-> $stable(precise_pc));
  // R6: no restore write and no issue can coincide
  p_write_no_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rw_en |-> !iss_ready);
endmodule

// File: tb/tb_hist_restore_unit.sv
module tb_hist_restore_unit;
  localparam int DEPTH = 4;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int PW = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [RW-1:0] iss_dst = '0;
  logic [PW-1:0] iss_pc = '0;
  logic [AW-1:0] iss_tag;
  logic [RW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic byp_valid = 1'b0;
  logic [RW-1:0] byp_dst = '0;
  logic [DW-1:0] byp_data = '0;
  logic cmp_valid = 1'b0;
  logic [AW-1:0] cmp_tag = '0;
  logic cmp_exc = 1'b0;
  logic pipe_idle = 1'b0;
  logic rw_en;
  logic [RW-1:0] rw_addr;
  logic [DW-1:0] rw_data;
  logic restore_done;
  logic [PW-1:0] precise_pc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // register file model seen through the extra read port
  assign rd_data = 32'h0000_1000 + 32'(rd_addr) * 32'd3;

  hist_restore_unit #(.DEPTH(DEPTH), .RW(RW), .DW(DW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst(iss_dst), .iss_pc(iss_pc), .iss_tag(iss_tag), .rd_addr(rd_addr),
    .rd_data(rd_data), .byp_valid(byp_valid), .byp_dst(byp_dst),
    .byp_data(byp_data), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_exc(cmp_exc), .pipe_idle(pipe_idle), .rw_en(rw_en),
    .rw_addr(rw_addr), .rw_data(rw_data), .restore_done(restore_done),
    .precise_pc(precise_pc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; iss_valid = 1'b0; cmp_valid = 1'b0; byp_valid = 1'b0; pipe_idle = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [RW-1:0] d, input logic [PW-1:0] pc,
                       input bit bv, input logic [RW-1:0] bd, input logic [DW-1:0] bval,
                       input logic [AW-1:0] exp_tag);
    iss_valid = 1'b1; iss_dst = d; iss_pc = pc;
    byp_valid = bv; byp_dst = bd; byp_data = bval;
    #1;
    chk(iss_ready == 1'b1, "R4 ready for issue", iss_ready, 1);
    chk(iss_tag == exp_tag, "R1 tag", iss_tag, exp_tag);
    chk(rd_addr == d, "R1 read port address", rd_addr, d);
    @(negedge clk);
    iss_valid = 1'b0; byp_valid = 1'b0;
  endtask

  task automatic report(input logic [AW-1:0] t, input bit e);
    cmp_valid = 1'b1; cmp_tag = t; cmp_exc = e;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_exc = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(iss_ready == 1'b1, "R9 ready", iss_ready, 1);
    chk(iss_tag == '0, "R9 tag", iss_tag, 0);
    chk(rw_en == 1'b0, "R9 rw_en", rw_en, 0);
    chk(restore_done == 1'b0, "R9 done", restore_done, 0);
    chk(precise_pc == '0, "R8 pc zero before done", precise_pc, 0);
  endtask

  task automatic t_fill_free();
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      issue(RW'(i + 1), PW'(16'h10 + i), 1'b0, '0, '0, AW'(i));
    chk(iss_ready == 1'b0, "R4 full blocks", iss_ready, 0);
    report(2'd2, 1'b0);
    chk(iss_ready == 1'b0, "R4 still full after report", iss_ready, 0);
    @(negedge clk);
    chk(iss_ready == 1'b0, "R3 non-head finish frees nothing", iss_ready, 0);
    report(2'd0, 1'b0);
    @(negedge clk);
    chk(iss_ready == 1'b1, "R3 clean head freed", iss_ready, 1);
    report(2'd1, 1'b0);
    @(negedge clk); @(negedge clk);
    issue(5'd20, 16'h20, 1'b0, '0, '0, 2'd0);
    issue(5'd21, 16'h21, 1'b0, '0, '0, 2'd1);
    issue(5'd22, 16'h22, 1'b0, '0, '0, 2'd2);
    chk(iss_ready == 1'b0, "R4 full again after wrap", iss_ready, 0);
  endtask

  task automatic t_exception();
    do_reset();
    issue(5'd3, 16'h100, 1'b0, '0, '0, 2'd0);
    issue(5'd7, 16'h104, 1'b1, 5'd7, 32'hDEAD_BEEF, 2'd1);
    issue(5'd9, 16'h108, 1'b1, 5'd4, 32'h5555_0000, 2'd2);
    report(2'd0, 1'b1);
    chk(iss_ready == 1'b0, "R5 issue halts after head exception", iss_ready, 0);
    iss_valid = 1'b1; iss_dst = 5'd30; iss_pc = 16'hBAD;
    report(2'd1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk(rw_en == 1'b0, "R6 no write while busy", rw_en, 0);
      chk(iss_ready == 1'b0, "R5 stays halted", iss_ready, 0);
      @(negedge clk);
    end
    pipe_idle = 1'b1;
    @(negedge clk);
    chk(rw_en == 1'b1, "R6 write starts after idle", rw_en, 1);
    chk(rw_addr == 5'd9, "R7 first write youngest addr", rw_addr, 9);
    chk(rw_data == 32'h1000 + 27, "R7 first write old value", rw_data, 32'h1000 + 27);
    @(negedge clk);
    chk(rw_en == 1'b1, "R7 second write", rw_en, 1);
    chk(rw_addr == 5'd7, "R7 second write addr", rw_addr, 7);
    chk(rw_data == 32'hDEAD_BEEF, "R2 bypassed old value", rw_data, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(rw_en == 1'b1, "R7 third write", rw_en, 1);
    chk(rw_addr == 5'd3, "R7 head write addr", rw_addr, 3);
    chk(rw_data == 32'h1000 + 9, "R1 head old value", rw_data, 32'h1000 + 9);
    @(negedge clk);
    chk(rw_en == 1'b0, "R7 exactly three writes", rw_en, 0);
    chk(restore_done == 1'b1, "R8 done", restore_done, 1);
    chk(precise_pc == 16'h100, "R8 precise pc", precise_pc, 16'h100);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk(restore_done == 1'b1 && precise_pc == 16'h100, "R8 held", precise_pc, 16'h100);
    iss_valid = 1'b0;
  endtask

  task automatic t_exc_single();
    do_reset();
    pipe_idle = 1'b1;
    issue(5'd11, 16'h200, 1'b0, '0, '0, 2'd0);
    issue(5'd12, 16'h204, 1'b0, '0, '0, 2'd1);
    report(2'd0, 1'b0);
    report(2'd1, 1'b1);
    chk(iss_ready == 1'b0, "R5 halt on second head", iss_ready, 0);
    @(negedge clk);
    chk(rw_en == 1'b0, "R6 drain cycle no write", rw_en, 0);
    @(negedge clk);
    chk(rw_en == 1'b1 && rw_addr == 5'd12, "R7 single write addr", rw_addr, 12);
    chk(rw_data == 32'h1000 + 36, "R7 single write data", rw_data, 32'h1000 + 36);
    @(negedge clk);
    chk(rw_en == 1'b0, "R7 single write only", rw_en, 0);
    chk(precise_pc == 16'h204, "R8 precise pc after retire", precise_pc, 16'h204);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_free();
    t_exception();
    t_exc_single();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule